// File: doc/BRIEF.md
# Serial One-Step Majority-Logic Corrector for a (15,7) Cyclic Code

This block repairs a 15-bit received word of a (15,7) cyclic low-density parity-check code. The word is loaded into a 15-bit circular register. On each of the next 15 cycles, four parity-check sums are computed over the register. These four sums are orthogonal on the bit in the top position (bit 14). The bit is inverted when a majority of the sums is 1, and the register then rotates by one place. Each code position passes through the top slot exactly once, and the same small piece of voting logic serves all fifteen of them.

The parity-check rows are the fifteen cyclic shifts of a base row with ones at offsets {0,1,3,7}. The four rows that contain position 14 cover the positions {14,0,2,6}, {14,13,1,5}, {14,11,12,3} and {14,7,8,10}. No other position appears in more than one of these rows, so any pattern of up to two bit errors is removed. Decoding needs no iteration and no syndrome table, so the latency is fixed.

A client presents a word together with a one-cycle start pulse while the block is idle. Exactly 15 cycles later a one-cycle done pulse marks the corrected word on the output. The corrected word is in its original bit order.

Top module: `mlc_serial_corrector`

## Requirements
- R1: A start pulse seen while `busy_o` is 0 loads `word_i` into the register, and `busy_o` reads 1 from the following cycle.
- R2: In each correction step, check sum j is the XOR of the four register bits at positions ((14 - b_j) + b_k) mod 15, for k = 0..3, where b = {0,1,3,7}.
- R3: Bit 14 is inverted in a step only when at least 3 of the 4 check sums are 1. Otherwise it passes unchanged.
- R4: Every step rotates the register left by one: bit i moves to bit i+1, and the (possibly inverted) bit 14 moves to bit 0.
- R5: `done_o` is a single-cycle pulse that is high exactly 15 cycles after the clock edge that accepted the start. `busy_o` falls in that same cycle.
- R6: When `done_o` is high, `word_o` holds the corrected word in the original bit order. For any valid codeword with at most 2 bit errors, this is the error-free codeword.
- R7: A valid codeword (all 15 checks zero) is returned unchanged.
- R8: A start pulse that arrives while `busy_o` is 1 is ignored: the running correction and its result are unaffected.
- R9: While reset is held and after it is released, `busy_o` and `done_o` are 0 and `word_o` is all zeros.
- R10: A new start may be accepted in the same cycle that `done_o` is high, which allows back-to-back words every 16 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request to correct `word_i` |
| word_i | input | 15 | Received word |
| busy_o | output | 1 | Correction in progress |
| done_o | output | 1 | One-cycle pulse: `word_o` holds the result |
| word_o | output | 15 | Corrected word |

## Verification
The bench sends every codeword of the code through the block unchanged, every single-bit error position, and many double-error pairs. A design with a wrong tap set or rotation direction would fail to restore these words, or would damage clean ones. Triple-error words are compared against a serial majority model, which exposes a threshold set at 2 instead of 3. Start pulses in the middle of a correction would corrupt the register, or retrigger the counter and delay done, if the ignore rule were wrong. Back-to-back starts in the done cycle would be lost if the block only accepted work one cycle later.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  // Number of orthogonal checks per code bit
  localparam int unsigned NCHK = 4;
  // Offsets of the ones in the base parity-check row
  localparam int unsigned BASE_ROW [NCHK] = '{0, 1, 3, 7};

  // Position of tap k in the check row j that covers the top bit (n-1)
  function automatic int unsigned tap_pos(input int unsigned j,
                                          input int unsigned k,
                                          input int unsigned n);
    int unsigned shift;
    shift = (n - 1 - BASE_ROW[j] + n) % n;
    return (shift + BASE_ROW[k]) % n;
  endfunction
endpackage

// File: rtl/mlc_check_sums.sv
module mlc_check_sums #(
  parameter int unsigned N = 15
) (
  input  logic [N-1:0]              word,
  output logic [mlc_pkg::NCHK-1:0]  sums
);
  localparam int unsigned J = mlc_pkg::NCHK;

  logic [J-1:0][J-1:0] term;

  for (genvar j = 0; j < J; j++) begin : g_chk
    for (genvar k = 0; k < J; k++) begin : g_tap
      localparam int unsigned P = mlc_pkg::tap_pos(j, k, N);
      assign term[j][k] = word[P];
    end
    assign sums[j] = ^term[j];
  end
endmodule

// File: rtl/mlc_vote.sv
module mlc_vote #(
  parameter int unsigned J      = 4,
  parameter int unsigned THRESH = 3
) (
  input  logic [J-1:0] sums,
  output logic         flip
);
  localparam int unsigned CW = $clog2(J + 1);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < J; i++) begin
      ones = ones + CW'(sums[i]);
    end
    flip = (ones >= CW'(THRESH));
  end
endmodule

// File: rtl/mlc_seq.sv
module mlc_seq #(
  parameter int unsigned N = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int unsigned CW   = $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          cnt_en;

  assign load   = start & ~busy_q;
  assign step   = busy_q;
  assign cnt_en = load | busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (load) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q  <= cnt_d;
        busy_q <= busy_d;
      end
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R1: accepted start makes the block busy next cycle
  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R5: done lasts one cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: done only closes a busy run, and busy is low with it
  p_done_ends_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R5: step counter stays in range
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= LAST));
  // R8: a start while busy does not restart the count
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt_q != LAST) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/mlc_serial_corrector.sv
module mlc_serial_corrector #(
  parameter int unsigned N      = 15,
  parameter int unsigned THRESH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [N-1:0] word_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] word_o
);
  localparam int unsigned J   = mlc_pkg::NCHK;
  localparam int unsigned TOP = N - 1;

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic         load, step, busy, done;
  logic [J-1:0] sums;
  logic         flip;
  logic [N-1:0] sr_q, sr_d;
  logic         sr_en;

  mlc_seq #(.N(N)) u_seq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (start_i),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  mlc_check_sums #(.N(N)) u_sums (
    .word (sr_q),
    .sums (sums)
  );

  mlc_vote #(.J(J), .THRESH(THRESH)) u_vote (
    .sums (sums),
    .flip (flip)
  );

  assign sr_en = load | step;

  always_comb begin
    sr_d = sr_q;
    if (load)      sr_d = word_i;
    else if (step) sr_d = {sr_q[TOP-1:0], sr_q[TOP] ^ flip};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  sr_q <= '0;
    else if (sr_en)  sr_q <= sr_d;
  end

  assign busy_o = busy;
  assign done_o = done;
  assign word_o = sr_q;

  // R1: an accepted start captures the input word
  p_load_word_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    load |=> (sr_q == $past(word_i)));
  // R4: each step shifts the lower bits up by one place
  p_rotate_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step && !load) |=> (sr_q[TOP:1] == $past(sr_q[TOP-1:0])));
  // R3: below the threshold the top bit wraps around unchanged
  p_keep_bit_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step && $countones(sums) < THRESH) |=> (sr_q[0] == $past(sr_q[TOP])));
  // R3: at or above the threshold the top bit wraps around inverted
  p_flip_bit_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step && $countones(sums) >= THRESH) |=> (sr_q[0] != $past(sr_q[TOP])));
  // R9: idle after reset until a start arrives
  p_idle_no_done_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && !load) |=> !done);
endmodule

// File: tb/tb_mlc_serial_corrector.sv
module tb_mlc_serial_corrector;
  localparam int N = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [N-1:0] word_i = '0;
  logic         busy_o, done_o;
  logic [N-1:0] word_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  mlc_serial_corrector dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
    .busy_o(busy_o), .done_o(done_o), .word_o(word_o)
  );

  int base [4] = '{0, 1, 3, 7};

  function automatic bit is_codeword(input logic [N-1:0] w);
    for (int r = 0; r < N; r++) begin
      bit p = 0;
      for (int k = 0; k < 4; k++) p ^= w[(r + base[k]) % N];
      if (p) return 0;
    end
    return 1;
  endfunction

  // Serial majority reference: visit the top slot, vote over every row containing it
  function automatic logic [N-1:0] serial_fix(input logic [N-1:0] w);
    logic [N-1:0] v = w;
    for (int s = 0; s < N; s++) begin
      int ones = 0;
      for (int r = 0; r < N; r++) begin
        bit has_top = 0;
        bit p = 0;
        for (int k = 0; k < 4; k++) begin
          if ((r + base[k]) % N == N - 1) has_top = 1;
          p ^= v[(r + base[k]) % N];
        end
        if (has_top && p) ones++;
      end
      if (ones >= 3) v[N-1] = ~v[N-1];
      v = {v[N-2:0], v[N-1]};
    end
    return v;
  endfunction

  // Cycle model
  logic         m_busy, m_done;
  int           m_cnt;
  logic [N-1:0] m_exp, tb_exp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_cnt <= 0; m_exp <= '0;
    end else begin
      m_done <= 0;
      if (start_i && !m_busy) begin
        m_busy <= 1; m_cnt <= 0; m_exp <= tb_exp;
      end else if (m_busy) begin
        m_cnt <= m_cnt + 1;
        if (m_cnt == N - 1) begin
          m_busy <= 0; m_done <= 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (busy_o !== m_busy) begin
        errors++;
        $display("FAIL R1/R8 busy_o actual=%0b expected=%0b t=%0t", busy_o, m_busy, $time);
      end
      checks++;
      if (done_o !== m_done) begin
        errors++;
        $display("FAIL R5/R10 done_o actual=%0b expected=%0b t=%0t", done_o, m_done, $time);
      end
      if (m_done) begin
        checks++;
        if (word_o !== m_exp) begin
          errors++;
          $display("FAIL R6/R2/R3/R4 word_o actual=%h expected=%h t=%0t", word_o, m_exp, $time);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input logic [N-1:0] w, input logic [N-1:0] e);
    while (m_busy) @(negedge clk);
    start_i = 1; word_i = w; tb_exp = e;
    @(negedge clk);
    start_i = 0; word_i = '0;
  endtask

  // R8: start pulses in the middle of a running correction
  task automatic run_intrude(input logic [N-1:0] w, input logic [N-1:0] e);
    run(w, e);
    repeat (4) @(negedge clk);
    start_i = 1; word_i = ~w; tb_exp = ~e;
    @(negedge clk);
    repeat (5) @(negedge clk);
    word_i = 15'h5a5a;
    @(negedge clk);
    start_i = 0; word_i = '0;
  endtask

  logic [N-1:0] cw [$];
  int unsigned seed = 32'h1234;

  function automatic int pick();
    seed = seed * 1103515245 + 12345;
    return int'((seed >> 16) % N);
  endfunction

  initial begin
    tb_exp = '0;
    for (int w = 0; w < (1 << N); w++)
      if (is_codeword(N'(w))) cw.push_back(N'(w));

    repeat (3) @(negedge clk);
    // R9: state during reset
    checks++;
    if (busy_o !== 0 || done_o !== 0 || word_o !== '0) begin
      errors++;
      $display("FAIL R9 in reset actual=%0b%0b%h expected=00 0000", busy_o, done_o, word_o);
    end
    rst_n = 1;
    repeat (5) @(negedge clk);
    checks++;
    if (busy_o !== 0 || done_o !== 0 || word_o !== '0) begin
      errors++;
      $display("FAIL R9 after reset actual=%0b%0b%h expected=00 0000", busy_o, done_o, word_o);
    end
    checks++;
    if (cw.size() != 128) begin
      errors++;
      $display("FAIL R7 codeword count actual=%0d expected=128", cw.size());
    end

    // R7 and R10: every codeword unchanged, issued back to back
    foreach (cw[i]) run(cw[i], cw[i]);

    // R6: every single-error position
    for (int p = 0; p < N; p++) begin
      logic [N-1:0] c = cw[(p * 7 + 3) % cw.size()];
      run(c ^ (N'(1) << p), c);
    end

    // R6: double errors
    for (int i = 0; i < 80; i++) begin
      int p = pick();
      int q = pick();
      logic [N-1:0] c = cw[(i * 13) % cw.size()];
      if (q == p) q = (p + 1 + i % (N - 1)) % N;
      if (q == p) q = (p + 1) % N;
      run(c ^ (N'(1) << p) ^ (N'(1) << q), c);
    end

    // R3: triple errors go beyond the correction radius; follow the serial vote
    for (int i = 0; i < 30; i++) begin
      int p = i % N;
      int q = (p + 1 + i % 7) % N;
      int r = (q + 2 + i % 5) % N;
      logic [N-1:0] w = cw[(i * 5) % cw.size()] ^ (N'(1) << p) ^ (N'(1) << q);
      if (r != p && r != q) w = w ^ (N'(1) << r);
      run(w, serial_fix(w));
    end

    // R8: ignored starts while busy
    for (int i = 0; i < 6; i++) begin
      logic [N-1:0] c = cw[(i * 29 + 1) % cw.size()];
      run_intrude(c ^ (N'(1) << (i * 2)), c);
    end

    repeat (20) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule